// File: doc/BRIEF.md
# Bypassable Control Register Cell

This cell holds one control input of an arithmetic slice, such as a subtract flag or a small operand-source select. In registered mode it is a clocked register with a clock enable. It also has two preset paths: an asynchronous one driven by an active-low load strobe, and a synchronous one taken on an enabled clock edge. Each preset path takes its value from its own constant data input. Both data inputs are written in active-low form, so the register stores their complement.

In bypass mode the cell stops acting as a register on the clock. The enable and the synchronous load still gate the output, in the same priority order, but they act without waiting for a clock edge. When the enable is low the output keeps its last value, which makes it level-sensitive storage. In this mode the asynchronous load has no effect. The width is a parameter (`W`, default 2), so one cell can serve a single flag or a two-bit select. The bypass and both preset data inputs are meant to be tied to constants.

Top module: `ctrl_bypass_reg`

## Requirements
- R1: With `bypass`=0 and `al_n`=0, `q` equals the bitwise inverse of `ad_n` straight away, and clock edges do not change it.
- R2: With `bypass`=0 and `al_n`=1, `q` changes only on a rising edge of `clk`. On a rising edge with `en`=0, `q` keeps its value.
- R3: With `bypass`=0 and `al_n`=1, a rising edge with `en`=1 and `sl_n`=0 loads `q` with the bitwise inverse of `sd_n`. This takes priority over `d`.
- R4: With `bypass`=0 and `al_n`=1, a rising edge with `en`=1 and `sl_n`=1 loads `q` with `d`.
- R5: With `bypass`=1 and `en`=1, `q` follows without a clock: it is the inverse of `sd_n` when `sl_n`=0 and it is `d` when `sl_n`=1.
- R6: With `bypass`=1, driving `al_n` low leaves `q` unchanged.
- R7: With `bypass`=1 and `en`=0, `q` keeps the value it had when `en` fell, whatever `d`, `sl_n` or `clk` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the register samples on the rising edge |
| al_n | input | 1 | Asynchronous load strobe, active low; has no effect in bypass mode |
| ad_n | input | W | Asynchronous load value in active-low form (static) |
| bypass | input | 1 | 1 selects transparent mode, 0 selects registered mode (static) |
| en | input | 1 | Enable, active high |
| sl_n | input | 1 | Synchronous load select, active low |
| sd_n | input | W | Synchronous load value in active-low form (static) |
| d | input | W | Data input |
| q | output | W | Stored or passed-through control value |

## Verification
The embedded assertions check on every clock edge that the registered cell follows its rules. An asserted async load must show the inverted preset. A disabled edge must hold `q`. An enabled edge must load either the inverted sync preset or `d`. While the enable is high, bypass mode must show the selected value. Some behaviour happens between clock edges or depends on history, and only the bench's scenarios show it. These cases are: `q` staying put while `d` moves with no edge, the bypass cell ignoring a low async load, and the bypass cell keeping its value while the enable is low. The bench sweeps every preset value, enable, load select and data word. It runs a registered instance and a bypassed instance side by side.

// File: rtl/ctrl_bypass_reg.sv
module ctrl_bypass_reg #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         al_n,
  input  logic [W-1:0] ad_n,
  input  logic         bypass,
  input  logic         en,
  input  logic         sl_n,
  input  logic [W-1:0] sd_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] nxt;
  logic [W-1:0] q_reg;
  logic [W-1:0] q_lat;
  logic         al_eff_n;

  assign nxt      = sl_n ? d : ~sd_n;
  assign al_eff_n = al_n | bypass;

  always_ff @(posedge clk or negedge al_eff_n) begin
    if (!al_eff_n)
      q_reg <= ~ad_n;
    else if (en)
      q_reg <= nxt;
  end

  always_latch begin
    if (en)
      q_lat = nxt;
  end

  assign q = bypass ? q_lat : q_reg;

  assert_async_preset_R1: assert property (@(posedge clk) disable iff (bypass)
    !al_n |-> (q == ~ad_n));

  assert_hold_disabled_R2: assert property (@(posedge clk) disable iff (!al_n || bypass)
    !en |=> $stable(q));

  assert_sync_preset_R3: assert property (@(posedge clk) disable iff (!al_n || bypass)
    (en && !sl_n) |=> (q == ~$past(sd_n)));

  assert_capture_d_R4: assert property (@(posedge clk) disable iff (!al_n || bypass)
    (en && sl_n) |=> (q == $past(d)));

  assert_bypass_follow_R5: assert property (@(posedge clk) disable iff (!bypass)
    en |-> (q == (sl_n ? d : ~sd_n)));

endmodule

// File: tb/ctrl_bypass_reg_tb.sv
module ctrl_bypass_reg_tb_top;
  localparam int W = 2;

  logic         clk = 1'b0;
  logic         al_n = 1'b1;
  logic [W-1:0] ad_n = '0;
  logic         en = 1'b0;
  logic         sl_n = 1'b1;
  logic [W-1:0] sd_n = '0;
  logic [W-1:0] d = '0;
  logic [W-1:0] q_r, q_b;
  logic [W-1:0] exp_r, exp_b;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  ctrl_bypass_reg #(.W(W)) dut_i (
    .clk(clk), .al_n(al_n), .ad_n(ad_n), .bypass(1'b0), .en(en),
    .sl_n(sl_n), .sd_n(sd_n), .d(d), .q(q_r));

  ctrl_bypass_reg #(.W(W)) dut_byp_i (
    .clk(clk), .al_n(al_n), .ad_n(ad_n), .bypass(1'b1), .en(en),
    .sl_n(sl_n), .sd_n(sd_n), .d(d), .q(q_b));

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Lower en first so the bypass latch never captures an intermediate value.
  task automatic drive(input logic e, input logic s, input logic [W-1:0] dv);
    en = 1'b0;
    #1;
    sl_n = s;
    d = dv;
    #1;
    en = e;
    if (e) exp_b = s ? dv : ~sd_n;
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    drive(1'b1, 1'b1, '0);
    #2 check("R5 bypass initial follow", q_b, exp_b);

    for (int a = 0; a < 4; a++) begin
      @(negedge clk);
      ad_n = W'(a);
      al_n = 1'b0;
      #2;
      check("R1 async preset", q_r, ~W'(a));
      check("R6 bypass ignores async load", q_b, exp_b);
      @(negedge clk);
      check("R1 clock ignored under async load", q_r, ~W'(a));
      al_n = 1'b1;
      exp_r = ~W'(a);
      en = 1'b0;
      #2 check("R6 bypass after async pulse", q_b, exp_b);
    end

    for (int s = 0; s < 4; s++) begin
      sd_n = W'(s);
      for (int v = 0; v < 16; v++) begin
        @(negedge clk);
        drive(v[3], v[2], v[1:0]);
        #2;
        check("R2 no change without edge", q_r, exp_r);
        if (v[3]) check(v[2] ? "R5 bypass d" : "R5 bypass sync preset", q_b, exp_b);
        else      check("R7 bypass hold", q_b, exp_b);
        d = ~v[1:0];
        #2;
        check("R2 d change without edge", q_r, exp_r);
        if (!v[3]) check("R7 bypass hold after d change", q_b, exp_b);
        else exp_b = v[2] ? ~v[1:0] : ~sd_n;
        d = v[1:0];
        if (v[3]) exp_b = v[2] ? v[1:0] : ~sd_n;
        @(posedge clk);
        if (v[3]) exp_r = v[2] ? v[1:0] : ~sd_n;
        @(negedge clk);
        if (!v[3])     check("R2 hold when disabled", q_r, exp_r);
        else if (!v[2]) check("R3 sync preset", q_r, exp_r);
        else           check("R4 capture d", q_r, exp_r);
        if (!v[3]) check("R7 bypass hold across clock", q_b, exp_b);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule